// File: doc/BRIEF.md
# 32-bit Integer ALU with Flags

A purely combinational arithmetic-logic unit for a small single-cycle RISC datapath. It receives two 32-bit operands, a 4-bit operation selector and a flag that marks the operation as unsigned arithmetic. From these it forms a 32-bit result, a zero flag and a signed-overflow flag. There is no clock and no state: every output follows its inputs within the same evaluation.

The add and subtract paths share a single carry chain. Subtraction inverts the second operand and forces the chain's carry-in to one. Set-on-less-than reuses that subtraction and reports its top sum bit in the lowest result bit. Branch-equality tests are made by subtracting and reading the zero flag. Shifts, multiply, divide and the decoding of instruction fields into the operation selector belong to other blocks.

Top module: `alu_core`

## Requirements
- R1: The selector code 0000 gives the bitwise AND of the operands, 0001 gives the bitwise OR, and 1100 gives the bitwise NOR.
- R2: The selector code 0010 gives the sum a + b, modulo 2^32.
- R3: The selector code 0110 gives a - b, which is formed as a + ~b + 1, modulo 2^32.
- R4: The selector code 0111 gives a result whose bit 0 is bit 31 of (a + ~b + 1) and whose bits 31..1 are all zero.
- R5: zero_o is 1 exactly when all 32 bits of result_o are 0.
- R6: For codes 0010 and 0110 with unsigned_i = 0, overflow_o equals the carry into bit 31 XOR the carry out of bit 31.
- R7: While unsigned_i = 1, overflow_o is 0 for every selector code.
- R8: For codes 0000, 0001, 1100 and 0111, overflow_o is 0.
- R9: Any selector code not listed above gives a result of all zeros, so zero_o = 1 and overflow_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 4 | Operation selector |
| unsigned_i | input | 1 | 1 marks the operation as unsigned, which suppresses overflow |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | 1 when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of an add or subtract |

## Verification
All three outputs are due in the same cycle as the stimulus, because no register lies between the operand ports and the flags. The bench changes the inputs just after a rising clock edge. It reads result_o, zero_o and overflow_o at the following falling edge, half a period later, after the carry chain and the flag logic have settled. Expected values come from bench functions that use plain 33-bit arithmetic, applied to random and directed operands, including the two's-complement extremes where overflow begins.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_AND = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OP_NOR = 4'b1100;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_msb_o,
  output logic             carry_out_o
);
  logic [WIDTH-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;

  // ripple chain, one full-adder cell per bit
  always_comb begin
    logic c;
    c           = sub_i;
    carry_msb_o = 1'b0;
    sum_o       = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i == WIDTH - 1) carry_msb_o = c;
      sum_o[i] = a_i[i] ^ b_eff[i] ^ c;
      c        = (a_i[i] & b_eff[i]) | (a_i[i] & c) | (b_eff[i] & c);
    end
    carry_out_o = c;
  end

  always_comb begin
    AST_CHAIN_SUM: assert (sum_o == a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i}); // R2 R3
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_NOR:  res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             carry_msb_i,
  input  logic             carry_out_i,
  input  logic             arith_i,
  input  logic             unsigned_i,
  output logic             zero_o,
  output logic             overflow_o
);
  assign zero_o     = ~|result_i;
  assign overflow_o = arith_i & ~unsigned_i & (carry_msb_i ^ carry_out_i);

  always_comb begin
    AST_ZERO_MATCH: assert (zero_o == (result_i == '0)); // R5
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             unsigned_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);
  logic             use_sub;
  logic             arith;
  logic             logic_op;
  logic [WIDTH-1:0] sum;
  logic             carry_msb;
  logic             carry_out;
  logic [WIDTH-1:0] logic_res;

  assign use_sub  = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign arith    = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign logic_op = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_NOR);

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .a_i         (a_i),
    .b_i         (b_i),
    .sub_i       (use_sub),
    .sum_o       (sum),
    .carry_msb_o (carry_msb),
    .carry_out_o (carry_out)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .res_o (logic_res)
  );

  always_comb begin
    if (arith)               result_o = sum;
    else if (op_i == OP_SLT) result_o = {{(WIDTH-1){1'b0}}, sum[WIDTH-1]};
    else                     result_o = logic_res;
  end

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .result_i    (result_o),
    .carry_msb_i (carry_msb),
    .carry_out_i (carry_out),
    .arith_i     (arith),
    .unsigned_i  (unsigned_i),
    .zero_o      (zero_o),
    .overflow_o  (overflow_o)
  );

  always_comb begin
    AST_UNSIGNED_NO_OVF: assert (!(unsigned_i && overflow_o)); // R7
    AST_LOGIC_NO_OVF: assert (!((logic_op || op_i == OP_SLT) && overflow_o)); // R8
    AST_SLT_UPPER_ZERO: assert (op_i != OP_SLT || result_o[WIDTH-1:1] == '0); // R4
    AST_ILLEGAL_ZERO: assert (arith || logic_op || op_i == OP_SLT
                              || (result_o == '0 && zero_o && !overflow_o)); // R9
  end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic        uns;
  logic [31:0] res;
  logic        zf, of;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  alu_core u_dut (
    .a_i(a), .b_i(b), .op_i(op), .unsigned_i(uns),
    .result_o(res), .zero_o(zf), .overflow_o(of)
  );

  // reference model: {overflow, zero, result}
  function automatic logic [33:0] ref_alu(logic [31:0] x, logic [31:0] y,
                                          logic [3:0] o, logic u);
    logic [31:0] r;
    logic [32:0] full;
    logic [31:0] low;
    logic        c_in_msb, ov;
    logic        sub;
    sub  = (o == 4'b0110) || (o == 4'b0111);
    full = {1'b0, x} + {1'b0, sub ? ~y : y} + 33'(sub);
    low  = {1'b0, x[30:0]} + {1'b0, (sub ? ~y[30:0] : y[30:0])} + 32'(sub);
    c_in_msb = low[31];
    ov = 1'b0;
    case (o)
      4'b0000: r = x & y;
      4'b0001: r = x | y;
      4'b1100: r = ~(x | y);
      4'b0010, 4'b0110: begin
        r  = full[31:0];
        ov = !u && (c_in_msb ^ full[32]);
      end
      4'b0111: r = {31'b0, full[31]};
      default: r = 32'b0;
    endcase
    return {ov, (r == 32'b0), r};
  endfunction

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'b0000, 4'b0001, 4'b1100: return "R1";
      4'b0010: return "R2";
      4'b0110: return "R3";
      4'b0111: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h op=%b uns=%b got=%h exp=%h", tag, a, b, op, uns, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] x, logic [31:0] y, logic [3:0] o, logic u);
    logic [33:0] e;
    @(posedge clk);
    #1;
    a = x; b = y; op = o; uns = u;
    @(negedge clk);
    e = ref_alu(x, y, o, u);
    chk(tag_of(o), res, e[31:0]);
    chk("R5", 32'(zf), 32'(e[32]));
    if (u) chk("R7", 32'(of), 32'(e[33]));
    else if (o == 4'b0010 || o == 4'b0110) chk("R6", 32'(of), 32'(e[33]));
    else chk("R8", 32'(of), 32'(e[33]));
  endtask

  localparam logic [3:0] OPS [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  initial begin
    a = '0; b = '0; op = 4'b0000; uns = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: AND of zeros
    chk("R5", 32'(zf), 32'd1);
    chk("R1", res, 32'd0);
    chk("R8", 32'(of), 32'd0);

    // directed corners
    apply(32'h00000d00, 32'h00003c00, 4'b0000, 1'b0);          // R1
    apply(32'h00000d00, 32'h00003c00, 4'b0001, 1'b0);          // R1
    apply(32'h00000d00, 32'h00003c00, 4'b1100, 1'b0);          // R1
    apply(32'h7fffffff, 32'h00000001, 4'b0010, 1'b0);          // R6 overflow
    apply(32'h7fffffff, 32'h00000001, 4'b0010, 1'b1);          // R7 suppressed
    apply(32'h80000000, 32'h00000001, 4'b0110, 1'b0);          // R6 overflow
    apply(32'h80000000, 32'h00000001, 4'b0110, 1'b1);          // R7
    apply(32'hffffffff, 32'h00000001, 4'b0010, 1'b0);          // R2 wrap, no ovf
    apply(32'h12345678, 32'h12345678, 4'b0110, 1'b0);          // R3 equal -> zero
    apply(32'h80000000, 32'h80000000, 4'b0010, 1'b0);          // R6 neg overflow
    apply(32'hffffffff, 32'h00000001, 4'b0111, 1'b0);          // R4 -1 < 1
    apply(32'h00000001, 32'hffffffff, 4'b0111, 1'b0);          // R4 1 !< -1
    apply(32'h80000000, 32'h00000001, 4'b0111, 1'b0);          // R4 sign bit of wrapped diff
    apply(32'hdeadbeef, 32'hcafef00d, 4'b1010, 1'b0);          // R9
    apply(32'hffffffff, 32'hffffffff, 4'b1111, 1'b0);          // R9

    // constrained random
    void'($urandom(32'h5eed_2301));
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] x, y;
      logic [3:0]  o;
      int          sel;
      sel = $urandom_range(0, 7);
      o   = (sel < 6) ? OPS[sel] : 4'($urandom);
      x   = $urandom;
      y   = $urandom;
      case ($urandom_range(0, 7))
        0: y = x;
        1: x = 32'h7fffffff;
        2: x = 32'h80000000;
        default: ;
      endcase
      apply(x, y, o, 1'($urandom_range(0, 3) == 0));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule